// File: doc/BRIEF.md
# Timing Unit Sync and Busy Controller

This block sits between an external timing unit and a pixel readout chip. While idle it passes the external shutter through to the chip. When a sync is requested, either by a local command or by a rising edge on the external zero-time line, it runs a fixed sequence. The sequence closes the chip shutter, optionally pulses the chip reset around a zero-time pulse, holds the shutter closed for a settle interval and then hands the shutter back to the external line. All durations are counted in cycles of the 25 ns block clock.

The same block produces the busy line toward the timing unit. Busy rises when the local output buffer reports almost-full or when a halt command is active, since a halt stops draining and the buffer fills. Busy lines from the other readout boards are synchronised and ORed in, so one wire carries the combined state.

Inputs that come from off-board (external shutter, external zero-time and peer busy lines) pass through a synchroniser chain of `SYNC_STAGES` flops. Local commands are synchronous to the clock. The reset is asynchronous, active low, and is released through a two-flop chain.

Top module: `tsync_busy_ctrl`

## Requirements
- R1: When no sequence is running, `chip_shutter_o` equals `ext_shutter_i` delayed by SYNC_STAGES+1 clock cycles.
- R2: A rising edge of `sync_start_i` starts a sequence at the next clock edge. A rising edge of `ext_t0_i` starts one SYNC_STAGES+1 edges after it is sampled. A start is the moment `chip_shutter_o` goes to 0.
- R3: After a start, the shutter is 0 and both `chip_t0_o` and `chip_rst_o` are 0 for CLOSE_CYC cycles (default 2). One lead cycle follows.
- R4: `chip_t0_o` is 1 for exactly PULSE_CYC cycles (default 1, i.e. 25 ns), and the shutter stays 0 throughout.
- R5: If `chip_rst_en_i` is 1 at the start, `chip_rst_o` is 1 for the lead cycle, the pulse cycles and one trailing cycle. If it is 0 at the start, `chip_rst_o` stays 0 for the whole sequence.
- R6: After `chip_t0_o` falls, the shutter stays 0 for SETTLE_CYC+1 cycles (default 66, i.e. 1.65 us). On the following cycle it follows the external shutter again.
- R7: Start requests that occur while a sequence is running are ignored. A request held high across the end of a sequence does not start a new one.
- R8: `busy_o` is 1 one cycle after `buf_afull_i` is 1, and falls one cycle after it clears, unless another busy source is active.
- R9: `busy_o` is 1 one cycle after `halt_i` is 1.
- R10: Any bit of `peer_busy_i` drives `busy_o` to 1 SYNC_STAGES+1 cycles later.
- R11: While reset is asserted, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 25 ns period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_shutter_i | input | 1 | Shutter from the timing unit (asynchronous) |
| ext_t0_i | input | 1 | Zero-time request from the timing unit (asynchronous) |
| sync_start_i | input | 1 | Local sync command, rising edge starts a sequence |
| chip_rst_en_i | input | 1 | Selects whether the chip reset is pulsed in a sequence |
| buf_afull_i | input | 1 | Output buffer almost-full flag |
| halt_i | input | 1 | Halt command, stops draining |
| peer_busy_i | input | N_PEERS | Busy lines from other readout boards (asynchronous) |
| chip_shutter_o | output | 1 | Shutter to the pixel chip |
| chip_t0_o | output | 1 | Zero-time pulse to the pixel chip |
| chip_rst_o | output | 1 | Reset to the pixel chip |
| busy_o | output | 1 | Combined busy to the timing unit |

## Verification
A sequencer stuck in a wrong state or loaded with a wrong count shows at the chip pins within one sequence. The zero-time pulse moves, the reset loses its lead or trail cycle, or the shutter reopens early. A cycle-by-cycle scoreboard catches any of these on the first cycle that differs. A broken edge detector shows as a second sequence, and the idle cycles that are checked after every sequence reveal it. A fault in the busy path is visible one cycle after the local flag changes and SYNC_STAGES+1 cycles after a peer line changes.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLOSE  = 3'd1,
    ST_LEAD   = 3'd2,
    ST_PULSE  = 3'd3,
    ST_TRAIL  = 3'd4,
    ST_SETTLE = 3'd5
  } tsb_state_e;

  function automatic int tsb_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tsb_sync.sv
module tsb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tsb_seq.sv
module tsb_seq
  import tsb_pkg::*;
#(
  parameter int CLOSE_CYC  = 2,
  parameter int PULSE_CYC  = 1,
  parameter int SETTLE_CYC = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_shutter_s_i,
  input  logic trig_i,
  input  logic rst_en_i,
  output logic chip_shutter_o,
  output logic chip_t0_o,
  output logic chip_rst_o
);

  localparam int MAXD  = tsb_max3(CLOSE_CYC, PULSE_CYC, SETTLE_CYC);
  localparam int CNT_W = $clog2(MAXD + 1);

  tsb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rst_en_q, rst_en_d;
  logic             trig_prev_q;
  logic             trig_edge;
  logic             cnt_zero;
  logic             shutter_d, t0_d, crst_d;
  logic             shutter_q, t0_q, crst_q;

  assign trig_edge = trig_i & ~trig_prev_q;
  assign cnt_zero  = (cnt_q == '0);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    rst_en_d = rst_en_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_edge) begin
          state_d  = ST_CLOSE;
          cnt_d    = CNT_W'(CLOSE_CYC - 1);
          rst_en_d = rst_en_i;
        end
      end
      ST_CLOSE: begin
        if (cnt_zero) begin
          state_d = ST_LEAD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_LEAD: begin
        state_d = ST_PULSE;
        cnt_d   = CNT_W'(PULSE_CYC - 1);
      end
      ST_PULSE: begin
        if (cnt_zero) begin
          state_d = ST_TRAIL;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_TRAIL: begin
        state_d = ST_SETTLE;
        cnt_d   = CNT_W'(SETTLE_CYC - 1);
      end
      ST_SETTLE: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // output decode of the next state, registered below
  always_comb begin
    shutter_d = 1'b0;
    t0_d      = 1'b0;
    crst_d    = 1'b0;
    unique case (state_d)
      ST_IDLE:   shutter_d = ext_shutter_s_i;
      ST_LEAD:   crst_d    = rst_en_d;
      ST_PULSE: begin
        t0_d   = 1'b1;
        crst_d = rst_en_d;
      end
      ST_TRAIL:  crst_d    = rst_en_d;
      default: begin
        shutter_d = 1'b0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rst_en_q    <= 1'b0;
      trig_prev_q <= 1'b0;
      shutter_q   <= 1'b0;
      t0_q        <= 1'b0;
      crst_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      rst_en_q    <= rst_en_d;
      trig_prev_q <= trig_i;
      shutter_q   <= shutter_d;
      t0_q        <= t0_d;
      crst_q      <= crst_d;
    end
  end

  assign chip_shutter_o = shutter_q;
  assign chip_t0_o      = t0_q;
  assign chip_rst_o     = crst_q;

  // checking counters for the assertions
  localparam int SET_SAT = SETTLE_CYC + 1;
  localparam int SW      = $clog2(SET_SAT + 1);
  localparam int PW      = $clog2(PULSE_CYC + 2);

  logic [SW-1:0] since_t0_q;
  logic [PW-1:0] pulse_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_t0_q  <= SW'(SET_SAT);
      pulse_len_q <= '0;
    end else begin
      if (t0_q)                          since_t0_q <= '0;
      else if (since_t0_q != SW'(SET_SAT)) since_t0_q <= since_t0_q + 1'b1;
      if (!t0_q)                          pulse_len_q <= '0;
      else if (pulse_len_q != '1)         pulse_len_q <= pulse_len_q + 1'b1;
    end
  end

  // R4: the pulse never coexists with an open shutter
  a_r4_t0_shutter_closed: assert property (@(posedge clk) disable iff (!rst_n)
    chip_t0_o |-> !chip_shutter_o);

  // R4: pulse width is exactly the configured count
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_t0_o) |-> (pulse_len_q == PW'(PULSE_CYC)));

  // R3: the shutter was already closed before the pulse rose
  a_r3_closed_before_t0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_t0_o) |-> $past(!chip_shutter_o));

  // R5: an enabled reset leads and trails the pulse
  a_r5_rst_leads: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chip_t0_o) && chip_rst_o) |-> $past(chip_rst_o));
  a_r5_rst_trails: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(chip_t0_o) && $past(chip_rst_o)) |-> chip_rst_o);

  // R6: shutter reopens only after the settle interval
  a_r6_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_shutter_o) |-> (since_t0_q >= SW'(SET_SAT)));

  // R7: a sequence can only be entered from idle
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_CLOSE) |=> (state_q != ST_CLOSE));

endmodule

// File: rtl/tsb_busy.sv
module tsb_busy #(
  parameter int N_PEERS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               afull_i,
  input  logic               halt_i,
  input  logic [N_PEERS-1:0] peer_s_i,
  output logic               busy_o
);

  logic busy_d, busy_q;
  logic peer_any;

  assign peer_any = |peer_s_i;

  always_comb begin
    busy_d = afull_i | halt_i | peer_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  a_r8_afull_busy: assert property (@(posedge clk) disable iff (!rst_n)
    afull_i |=> busy_o);

  a_r9_halt_busy: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> busy_o);

  a_r10_peer_busy: assert property (@(posedge clk) disable iff (!rst_n)
    peer_any |=> busy_o);

  a_r8_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!afull_i && !halt_i && !peer_any) |=> !busy_o);

endmodule

// File: rtl/tsync_busy_ctrl.sv
module tsync_busy_ctrl #(
  parameter int N_PEERS     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CLOSE_CYC   = 2,
  parameter int PULSE_CYC   = 1,
  parameter int SETTLE_CYC  = 65
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_shutter_i,
  input  logic               ext_t0_i,
  input  logic               sync_start_i,
  input  logic               chip_rst_en_i,
  input  logic               buf_afull_i,
  input  logic               halt_i,
  input  logic [N_PEERS-1:0] peer_busy_i,
  output logic               chip_shutter_o,
  output logic               chip_t0_o,
  output logic               chip_rst_o,
  output logic               busy_o
);

  localparam int XW = N_PEERS + 2;

  logic [1:0]         rst_chain_q;
  logic               rst_n_int;
  logic [XW-1:0]      ext_raw, ext_s;
  logic               ext_shutter_s, ext_t0_s;
  logic [N_PEERS-1:0] peer_s;
  logic               trig;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= 2'b00;
    else        rst_chain_q <= {rst_chain_q[0], 1'b1};
  end
  assign rst_n_int = rst_chain_q[1];

  assign ext_raw = {peer_busy_i, ext_t0_i, ext_shutter_i};

  tsb_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (ext_raw),
    .q_o   (ext_s)
  );

  assign ext_shutter_s = ext_s[0];
  assign ext_t0_s      = ext_s[1];
  assign peer_s        = ext_s[XW-1:2];
  assign trig          = sync_start_i | ext_t0_s;

  tsb_seq #(
    .CLOSE_CYC  (CLOSE_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n_int),
    .ext_shutter_s_i (ext_shutter_s),
    .trig_i          (trig),
    .rst_en_i        (chip_rst_en_i),
    .chip_shutter_o  (chip_shutter_o),
    .chip_t0_o       (chip_t0_o),
    .chip_rst_o      (chip_rst_o)
  );

  tsb_busy #(.N_PEERS(N_PEERS)) u_busy (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .afull_i  (buf_afull_i),
    .halt_i   (halt_i),
    .peer_s_i (peer_s),
    .busy_o   (busy_o)
  );

  // R11: outputs quiet while the block is held in reset
  always_comb begin
    if (!rst_n_int) begin
      a_r11_reset_quiet: assert (!chip_shutter_o && !chip_t0_o && !chip_rst_o && !busy_o);
    end
  end

endmodule

// File: tb/tb_tsync_busy_ctrl.sv
module tb_tsync_busy_ctrl;

  localparam int NP    = 3;
  localparam int SS    = 2;
  localparam int CLOSE = 2;
  localparam int PULSE = 1;
  localparam int SETL  = 65;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ext_shutter, ext_t0, sync_start, rst_en, afull, halt;
  logic [NP-1:0] peers;
  logic          sh_o, t0_o, rst_o, busy_o;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    logic  sh;
    logic  t0;
    logic  rst;
    logic  busy;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  tsync_busy_ctrl #(
    .N_PEERS(NP), .SYNC_STAGES(SS), .CLOSE_CYC(CLOSE),
    .PULSE_CYC(PULSE), .SETTLE_CYC(SETL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ext_shutter_i(ext_shutter), .ext_t0_i(ext_t0),
    .sync_start_i(sync_start), .chip_rst_en_i(rst_en), .buf_afull_i(afull),
    .halt_i(halt), .peer_busy_i(peers), .chip_shutter_o(sh_o),
    .chip_t0_o(t0_o), .chip_rst_o(rst_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  task automatic push(input logic s, input logic t, input logic r,
                      input logic b, input string tag);
    exp_t e;
    e.sh = s; e.t0 = t; e.rst = r; e.busy = b; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic check_now(input logic s, input logic t, input logic r,
                           input logic b, input string tag);
    n_checks++;
    if ({sh_o, t0_o, rst_o, busy_o} !== {s, t, r, b}) begin
      n_errors++;
      $display("FAIL %s: got sh/t0/rst/busy=%b%b%b%b expected %b%b%b%b",
               tag, sh_o, t0_o, rst_o, busy_o, s, t, r, b);
    end
  endtask

  // monitor: compare one expected item per clock, after the edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check_now(e.sh, e.t0, e.rst, e.busy, e.tag);
    end
  end

  // full sync sequence as seen after the start edge
  task automatic push_seq(input logic r, input logic sh_after, input logic b,
                          input int n_idle, input string tag);
    for (int i = 0; i < CLOSE; i++) push(1'b0, 1'b0, 1'b0, b, {tag, " R3 close"});
    push(1'b0, 1'b0, r, b, {tag, " R5 lead"});
    for (int i = 0; i < PULSE; i++) push(1'b0, 1'b1, r, b, {tag, " R4 pulse"});
    push(1'b0, 1'b0, r, b, {tag, " R5 trail"});
    for (int i = 0; i < SETL; i++) push(1'b0, 1'b0, 1'b0, b, {tag, " R6 settle"});
    for (int i = 0; i < n_idle; i++) push(sh_after, 1'b0, 1'b0, b, {tag, " R7 idle after"});
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_shutter = 1'b1; ext_t0 = 1'b0; sync_start = 1'b0;
    rst_en = 1'b0; afull = 1'b1; halt = 1'b0; peers = '0;
    // R11: reset state with inputs that would otherwise drive outputs high
    repeat (3) begin
      @(negedge clk);
      check_now(1'b0, 1'b0, 1'b0, 1'b0, "R11 reset");
    end
    afull = 1'b0; ext_shutter = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_now(1'b0, 1'b0, 1'b0, 1'b0, "R11 after release");

    // R1: shutter passthrough latency SS+1
    ext_shutter = 1'b1;
    for (int i = 0; i < SS; i++) push(1'b0, 1'b0, 1'b0, 1'b0, "R1 rise latency");
    for (int i = 0; i < 3; i++)  push(1'b1, 1'b0, 1'b0, 1'b0, "R1 rise");
    drain();
    ext_shutter = 1'b0;
    for (int i = 0; i < SS; i++) push(1'b1, 1'b0, 1'b0, 1'b0, "R1 fall latency");
    for (int i = 0; i < 3; i++)  push(1'b0, 1'b0, 1'b0, 1'b0, "R1 fall");
    drain();
    ext_shutter = 1'b1;
    repeat (SS + 2) @(negedge clk);

    // R2 local start with reset enabled
    sync_start = 1'b1; rst_en = 1'b1;
    push_seq(1'b1, 1'b1, 1'b0, 3, "R2 local");
    @(negedge clk);
    sync_start = 1'b0; rst_en = 1'b0;
    drain();

    // R2 external start, reset disabled (R5)
    ext_t0 = 1'b1; rst_en = 1'b0;
    for (int i = 0; i < SS; i++) push(1'b1, 1'b0, 1'b0, 1'b0, "R2 ext latency");
    push_seq(1'b0, 1'b1, 1'b0, 3, "R2 ext R5 off");
    @(negedge clk);
    ext_t0 = 1'b0;
    drain();

    // R7 requests during a running sequence are dropped
    sync_start = 1'b1; rst_en = 1'b1;
    push_seq(1'b1, 1'b1, 1'b0, 8, "R7 retrig");
    @(negedge clk);
    sync_start = 1'b0;
    repeat (10) @(negedge clk);
    sync_start = 1'b1; rst_en = 1'b0;
    @(negedge clk);
    sync_start = 1'b0;
    repeat (3) @(negedge clk);
    ext_t0 = 1'b1;
    @(negedge clk);
    ext_t0 = 1'b0;
    drain();

    // R7 held request does not restart
    sync_start = 1'b1; rst_en = 1'b0;
    push_seq(1'b0, 1'b1, 1'b0, 8, "R7 held");
    drain();
    sync_start = 1'b0;
    @(negedge clk);

    // R8 almost-full
    afull = 1'b1;
    for (int i = 0; i < 3; i++) push(1'b1, 1'b0, 1'b0, 1'b1, "R8 afull set");
    drain();
    afull = 1'b0;
    for (int i = 0; i < 3; i++) push(1'b1, 1'b0, 1'b0, 1'b0, "R8 afull clear");
    drain();

    // R9 halt
    halt = 1'b1;
    for (int i = 0; i < 3; i++) push(1'b1, 1'b0, 1'b0, 1'b1, "R9 halt set");
    drain();
    halt = 1'b0;
    push(1'b1, 1'b0, 1'b0, 1'b0, "R9 halt clear");
    drain();

    // R10 each peer line, with synchroniser latency
    for (int p = 0; p < NP; p++) begin
      peers = NP'(1) << p;
      for (int i = 0; i < SS; i++) push(1'b1, 1'b0, 1'b0, 1'b0, "R10 peer latency");
      for (int i = 0; i < 2; i++)  push(1'b1, 1'b0, 1'b0, 1'b1, "R10 peer set");
      drain();
      peers = '0;
      for (int i = 0; i < SS; i++) push(1'b1, 1'b0, 1'b0, 1'b1, "R10 peer hold");
      push(1'b1, 1'b0, 1'b0, 1'b0, "R10 peer clear");
      drain();
    end

    // R8 busy is independent of a running sequence
    afull = 1'b1; sync_start = 1'b1; rst_en = 1'b1;
    push_seq(1'b1, 1'b1, 1'b1, 2, "R8 busy in seq");
    @(negedge clk);
    sync_start = 1'b0;
    drain();
    afull = 1'b0;
    push(1'b1, 1'b0, 1'b0, 1'b0, "R8 busy clear");
    drain();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule